// File: doc/BRIEF.md
# Double-to-Single Bit-Exact Format Converter

This block turns a 64-bit double-precision floating-point word into a 32-bit single-precision word without any arithmetic rounding. It is meant for the non-arithmetic store path of a floating-point unit, where a value has to move between formats with its bits intact. Denormal results are kept as they are, and a signalling NaN stays signalling. The result is formed in one of two ways. If the biased exponent lies in a narrow band just below the single-precision normal range, the block builds a single subnormal by shifting the full significand right. For every other exponent it copies fixed bit fields of the input, whatever value those fields represent.

The block is a two-stage pipeline with no backpressure. It accepts a word on every cycle that `in_valid` is high. Two cycles later it presents the converted word with `out_valid` high.

Top module: `d2s_converter`

## Requirements
- R1: The biased exponent is `in_data[62:52]`. The shift path is used exactly when this exponent is at least 874 and at most 896; the field path is used for 873, 897 and every other value.
- R2: On the shift path, the 53-bit significand `{1'b1, in_data[51:0]}` is shifted right logically by (926 - exponent) positions, which is 30 at exponent 896 and 52 at exponent 874. The low 23 bits of the shifted value form `out_data[22:0]`. Bits shifted out below bit 0 are dropped, with no rounding.
- R3: On the shift path, `out_data[31]` equals `in_data[63]` and `out_data[30:23]` is zero.
- R4: On the field path, `out_data[31:30]` equals `in_data[63:62]` and `out_data[29:0]` equals `in_data[58:29]`.
- R5: Zeros, infinities, NaNs and doubles outside the single range all take the field path with no special handling. For a NaN, the quiet bit `in_data[51]` appears unchanged at `out_data[22]`.
- R6: `out_valid` equals `in_valid` from two cycles earlier. A word can be accepted on every cycle, and gaps in the input appear as the same gaps at the output.
- R7: `rst` is synchronous and active-high. It clears both pipeline valid bits, so `out_valid` is low from the first clock edge of reset until a word accepted after reset reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_data | input | 64 | Double-precision input word |
| out_valid | output | 1 | Converted word is present this cycle |
| out_data | output | 32 | Single-precision result |

## Verification
A wrong path selection at the band edges shows up two cycles later as a whole-word mismatch. Exponents 873, 874, 896 and 897 are therefore driven in a back-to-back stream, so one slip by one in the band compare is caught on the first such word. An error in the shift amount moves the subnormal significand by a power of two. The all-ones fractions in the vectors show that error, and they also catch any rounding, because truncated low bits would turn into a carry. A pipeline valid bit that is stuck or misaligned shows up as a missing or extra result within two cycles of a gap in the input.

// File: rtl/d2s_pkg.sv
package d2s_pkg;
    localparam int DBL_W     = 64;
    localparam int SGL_W     = 32;
    localparam int DEXP_W    = 11;
    localparam int SEXP_W    = 8;
    localparam int DFRAC_W   = DBL_W - 1 - DEXP_W;
    localparam int SFRAC_W   = SGL_W - 1 - SEXP_W;
    localparam int SIG_W     = DFRAC_W + 1;
    localparam int SHAMT_W   = $clog2(SIG_W + 1);
    localparam int BAND_LO   = 874;
    localparam int BAND_HI   = 896;
    localparam int SHIFT_BASE = BAND_HI + (DFRAC_W - SFRAC_W) + 1;
    localparam int TOP_KEEP  = 2;
    localparam int LOW_W     = SGL_W - TOP_KEEP;
    localparam int LOW_MSB   = DBL_W - TOP_KEEP - (DEXP_W - SEXP_W) - 1;
    localparam int LOW_LSB   = LOW_MSB - LOW_W + 1;

    typedef struct packed {
        logic               valid;
        logic               den;
        logic               sign;
        logic [SHAMT_W-1:0] shamt;
        logic [SIG_W-1:0]   sig;
        logic [SGL_W-1:0]   fld;
    } stage1_t;

    typedef struct packed {
        logic             valid;
        logic [SGL_W-1:0] data;
    } stage2_t;
endpackage

// File: rtl/d2s_band_decode.sv
module d2s_band_decode
    import d2s_pkg::*;
(
    input  logic [DEXP_W-1:0]  exp_i,
    input  logic [DFRAC_W-1:0] frac_i,
    output logic               in_band_o,
    output logic [SHAMT_W-1:0] shamt_o,
    output logic [SIG_W-1:0]   sig_o
);
    localparam logic [DEXP_W:0] BASE_V = (DEXP_W+1)'(SHIFT_BASE);
    localparam logic [DEXP_W-1:0] LO_V = DEXP_W'(BAND_LO);
    localparam logic [DEXP_W-1:0] HI_V = DEXP_W'(BAND_HI);

    logic [DEXP_W:0] diff;

    always_comb begin
        in_band_o = (exp_i >= LO_V) && (exp_i <= HI_V);
        diff      = BASE_V - {1'b0, exp_i};
        shamt_o   = in_band_o ? diff[SHAMT_W-1:0] : '0;
        sig_o     = {1'b1, frac_i};
    end

    // R2
    always_comb begin
        if (in_band_o) begin
            shamt_range_chk: assert ((diff >= (DEXP_W+1)'(DFRAC_W - SFRAC_W + 1)) &&
                                     (diff <= (DEXP_W+1)'(DFRAC_W)));
        end
    end
endmodule

// File: rtl/d2s_denorm_shift.sv
module d2s_denorm_shift
    import d2s_pkg::*;
(
    input  logic               active_i,
    input  logic               sign_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic [SIG_W-1:0]   sig_i,
    output logic [SGL_W-1:0]   result_o
);
    logic [SIG_W-1:0] shifted;

    always_comb begin
        shifted  = sig_i >> shamt_i;
        result_o = {sign_i, {SEXP_W{1'b0}}, shifted[SFRAC_W-1:0]};
    end

    // R3: the shifted significand never reaches the exponent field
    always_comb begin
        if (active_i) begin
            fits_below_exp_chk: assert (shifted[SIG_W-1:SFRAC_W] == '0);
        end
    end
endmodule

// File: rtl/d2s_field_pick.sv
module d2s_field_pick
    import d2s_pkg::*;
(
    input  logic [TOP_KEEP-1:0] top_i,
    input  logic [LOW_W-1:0]    low_i,
    output logic [SGL_W-1:0]    fld_o
);
    always_comb begin
        fld_o = {top_i, low_i};
    end
endmodule

// File: rtl/d2s_converter.sv
module d2s_converter
    import d2s_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DBL_W-1:0] in_data,
    output logic             out_valid,
    output logic [SGL_W-1:0] out_data
);
    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;

    logic               band_in;
    logic [SHAMT_W-1:0] band_shamt;
    logic [SIG_W-1:0]   band_sig;
    logic [SGL_W-1:0]   pick_fld;
    logic [SGL_W-1:0]   den_res;

    d2s_band_decode u_decode (
        .exp_i     (in_data[DBL_W-2 -: DEXP_W]),
        .frac_i    (in_data[DFRAC_W-1:0]),
        .in_band_o (band_in),
        .shamt_o   (band_shamt),
        .sig_o     (band_sig)
    );

    d2s_field_pick u_pick (
        .top_i (in_data[DBL_W-1 -: TOP_KEEP]),
        .low_i (in_data[LOW_MSB:LOW_LSB]),
        .fld_o (pick_fld)
    );

    d2s_denorm_shift u_shift (
        .active_i (s1_q.valid & s1_q.den),
        .sign_i   (s1_q.sign),
        .shamt_i  (s1_q.shamt),
        .sig_i    (s1_q.sig),
        .result_o (den_res)
    );

    always_comb begin
        s1_d.valid = in_valid;
        s1_d.den   = band_in;
        s1_d.sign  = in_data[DBL_W-1];
        s1_d.shamt = band_shamt;
        s1_d.sig   = band_sig;
        s1_d.fld   = pick_fld;

        s2_d.valid = s1_q.valid;
        s2_d.data  = s1_q.den ? den_res : s1_q.fld;
    end

    always_ff @(posedge clk) begin
        s1_q <= s1_d;
        s2_q <= s2_d;
        if (rst) begin
            s1_q.valid <= 1'b0;
            s2_q.valid <= 1'b0;
        end
    end

    assign out_valid = s2_q.valid;
    assign out_data  = s2_q.data;

    // R6
    lat_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    // R6
    lat_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    // R7
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R3
    den_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(s1_q.den)) |->
            (out_data[SGL_W-1] == $past(in_data[DBL_W-1], 2)) &&
            (out_data[SGL_W-2 -: SEXP_W] == '0));

    // R4
    field_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(s1_q.den)) |->
            (out_data == {$past(in_data[DBL_W-1 -: TOP_KEEP], 2),
                          $past(in_data[LOW_MSB:LOW_LSB], 2)}));
endmodule

// File: tb/d2s_converter_tb.sv
module d2s_converter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    d2s_converter dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    localparam int NV = 14;
    localparam logic [95:0] VEC [NV] = '{
        {64'h0000000000000000, 32'h00000000}, // R5 +0
        {64'h8000000000000000, 32'h80000000}, // R5 -0
        {64'h3FF0000000000000, 32'h3F800000}, // R4 1.0
        {64'hFFF0000000000000, 32'hFF800000}, // R5 -inf
        {64'h7FF4000000000000, 32'h7FA00000}, // R5 signalling NaN
        {64'h3800000000000000, 32'h00400000}, // R1 exponent 896
        {64'h36A0000000000000, 32'h00000001}, // R1 exponent 874
        {64'hB6A0000000000000, 32'h80000001}, // R3 negative in band
        {64'h3810000000000000, 32'h00800000}, // R1 exponent 897
        {64'h3690000000000000, 32'h34800000}, // R1 exponent 873
        {64'h37FFFFFFFFFFFFFF, 32'h003FFFFF}, // R2 truncation, exp 895
        {64'hB80FFFFFFFFFFFFF, 32'h807FFFFF}, // R2 shift 30, negative
        {64'h7FEFFFFFFFFFFFFF, 32'h7F7FFFFF}, // R4 largest double
        {64'h0010000000000000, 32'h00800000}  // R5 out-of-range tiny
    };

    function automatic logic [31:0] ref_conv(input logic [63:0] x);
        int unsigned e;
        logic [63:0] m;
        e = int'(x[62:52]);
        if (e >= 874 && e <= 896) begin
            m = {11'd0, 1'b1, x[51:0]} >> (926 - e);
            return {x[63], 8'h00, m[22:0]};
        end
        return {x[63:62], x[58:29]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    logic [63:0] rnd_in [200];
    logic [31:0] rnd_ex [200];

    initial begin
        // R7: reset with valid input held high
        in_valid = 1'b1;
        in_data  = 64'h3FF0000000000000;
        repeat (3) @(negedge clk);
        chk("R7 out_valid during reset", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 out_valid after reset", {31'd0, out_valid}, 32'd0);

        // table stream, back to back
        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2) begin
                chk("R6 stream valid", {31'd0, out_valid}, 32'd1);
                chk("R1-table data", out_data, VEC[i-2][31:0]);
            end
            if (i < NV) begin
                in_valid = 1'b1;
                in_data  = VEC[i][95:32];
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end

        // R6: gap pattern 1,0,1
        in_valid = 1'b1; in_data = 64'h3800000000000000;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_data = 64'h3FF0000000000000;
        chk("R6 first of gap", {31'd0, out_valid}, 32'd1);
        chk("R2 first of gap", out_data, 32'h00400000);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 bubble", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk("R6 after bubble", {31'd0, out_valid}, 32'd1);
        chk("R4 after bubble", out_data, 32'h3F800000);
        @(negedge clk);
        chk("R6 drained", {31'd0, out_valid}, 32'd0);

        // random words, half forced into the band
        for (int i = 0; i < 200; i++) begin
            logic [63:0] w;
            w = {$urandom, $urandom};
            if (i % 2 == 0) w[62:52] = 11'(874 + ($urandom % 23));
            rnd_in[i] = w;
            rnd_ex[i] = ref_conv(w);
        end
        for (int i = 0; i < 202; i++) begin
            if (i >= 2) begin
                chk("R2 random valid", {31'd0, out_valid}, 32'd1);
                chk("R4 random data", out_data, rnd_ex[i-2]);
            end
            if (i < 200) begin
                in_valid = 1'b1;
                in_data  = rnd_in[i];
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end

        // R7: reset mid-stream drops in-flight words
        in_valid = 1'b1; in_data = 64'h0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        chk("R7 flush at reset", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk("R7 flush after reset", {31'd0, out_valid}, 32'd0);

        finish_run();
    end
endmodule